// File: doc/BRIEF.md
# Serial Port Interrupt Status Controller

This block produces the interrupt sources of a serial port that buffers words in FIFOs and keeps their state. From the fill levels of the transmit and receive FIFOs it derives two level-following conditions: transmit running low and receive filling up. It also watches receive activity, using a bit-period tick and an idle flag from the shift engine, and from that raises a receive timeout. It catches a receive overrun when a frame completes while the receive FIFO is already full.

The four raw conditions are held in a 4-bit status vector. Bit 3 is transmit low, bit 2 is receive high, bit 1 is receive timeout and bit 0 is receive overrun. A mask register of the same layout enables each source. The masked vector and a single combined interrupt line come from the two. A clear port uses write-one-to-clear semantics for the two sticky sources. The block also returns an accept strobe for the receive FIFO push, so that a frame arriving at a full FIFO is dropped and the stored words stay intact.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After synchronous reset the raw status reads 4'b1000, and the mask, the masked status and `irq` all read 0.
- R2: Raw bit 3 (transmit low) is 1 exactly when `tx_level` was at most DEPTH/2 at the previous clock edge. The enable state of the port does not qualify it.
- R3: Raw bit 2 (receive high) is 1 exactly when `rx_level` was at least DEPTH/2 at the previous clock edge.
- R4: Raw bit 1 (receive timeout) sets on the TIMEOUT_BITS-th clock edge at which `bit_tick`, `engine_idle` and a non-empty receive FIFO all hold. A cycle with the engine busy, with the FIFO empty or with a completed frame restarts the count. Ticks while the FIFO is empty never set it.
- R5: Raw bit 1 clears one edge after any of these: the receive FIFO is empty, a pop takes the last word (`rx_pop` with `rx_level` of 1), a frame completes, or a clear write with bit 1 set.
- R6: A frame completing with `rx_level` equal to DEPTH sets raw bit 0 (overrun) one edge later, and `rx_accept` is low for that frame. Otherwise `rx_accept` equals `rx_frame_done`.
- R7: Raw bit 0 stays set until a clear write with bit 0 set. A clear write with bit 0 at 0 leaves it set. If an overrun and a clear occur in the same cycle, the bit stays set.
- R8: Clear writes to bits 3 and 2 have no effect. Those bits only follow the FIFO levels.
- R9: A mask write loads all four mask bits at the next edge. Each masked status bit is the AND of its raw bit and its mask bit.
- R10: `irq` is the OR of the four masked status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W | Words held in the transmit FIFO |
| rx_level | input | LVL_W | Words held in the receive FIFO |
| rx_frame_done | input | 1 | One-cycle strobe: the shift engine completed a receive frame |
| rx_pop | input | 1 | One-cycle strobe: a word is read out of the receive FIFO |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| engine_idle | input | 1 | Shift engine is not moving a frame |
| mask_wr | input | 1 | Load the mask register |
| mask_wdata | input | 4 | New mask value |
| clr_wr | input | 1 | Clear write strobe |
| clr_wdata | input | 4 | Clear bits; a 1 clears a sticky source |
| rx_accept | output | 1 | Push enable for the receive FIFO; low on overrun |
| raw_status | output | 4 | Raw conditions {tx low, rx high, timeout, overrun} |
| mask_status | output | 4 | Mask register contents |
| masked_status | output | 4 | Raw status ANDed with the mask |
| irq | output | 1 | Combined interrupt |

## Verification
Every pair of transmit and receive levels from empty to full is swept, so that an off-by-one threshold shows up as a wrong raw bit at level 4 or 5. The timeout is probed at 31 and 32 ticks, after a busy cycle in the middle of a count, and with ticks on an empty FIFO. A counter that does not restart, or that runs on an empty FIFO, would fire early. Each clearing path of the timeout is exercised on its own. For overrun, the bench checks that the push is refused at a full FIFO, that a zero clear bit leaves the flag alone, and that a clear in the same cycle as an overrun loses. A design that gave the clear priority would drop an overrun. All sixteen mask values are applied against a fixed raw vector.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int N_SRC   = 4;
  localparam int IDX_TX  = 3;
  localparam int IDX_RX  = 2;
  localparam int IDX_TO  = 1;
  localparam int IDX_OVR = 0;
  typedef logic [N_SRC-1:0] irq_vec_t;
endpackage

// File: rtl/sio_irq_level_cmp.sv
module sio_irq_level_cmp #(
  parameter int LVL_W    = 4,
  parameter int THR      = 4,
  parameter bit AT_ABOVE = 1'b0,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  output logic             flag_q
);
  logic hit;

  generate
    if (AT_ABOVE) begin : g_above
      assign hit = (level >= LVL_W'(THR));
    end else begin : g_below
      assign hit = (level <= LVL_W'(THR));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag_q <= RST_VAL;
    else     flag_q <= hit;
  end
endmodule

// File: rtl/sio_irq_rx_timeout.sv
module sio_irq_rx_timeout #(
  parameter int LVL_W        = 4,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_pop,
  input  logic             frame_done,
  input  logic             idle,
  input  logic             bit_tick,
  input  logic             sw_clr,
  output logic             flag_q
);
  localparam int CNT_W = (TIMEOUT_BITS > 1) ? $clog2(TIMEOUT_BITS) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic fifo_empty, drain, restart, run, expire, hw_clr;

  assign fifo_empty = (rx_level == '0);
  assign drain      = rx_pop && (rx_level == LVL_W'(1));
  assign hw_clr     = fifo_empty || drain || frame_done;
  assign restart    = hw_clr || !idle;
  assign run        = !restart && bit_tick;
  assign expire     = run && (cnt_q == CNT_W'(TIMEOUT_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || expire) cnt_q <= '0;
    else if (run)                 cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                   flag_q <= 1'b0;
    else if (expire)           flag_q <= 1'b1;
    else if (hw_clr || sw_clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/sio_irq_sticky.sv
module sio_irq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int TIMEOUT_BITS = 32,
  parameter int LVL_W        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_frame_done,
  input  logic             rx_pop,
  input  logic             bit_tick,
  input  logic             engine_idle,
  input  logic             mask_wr,
  input  logic [3:0]       mask_wdata,
  input  logic             clr_wr,
  input  logic [3:0]       clr_wdata,
  output logic             rx_accept,
  output logic [3:0]       raw_status,
  output logic [3:0]       mask_status,
  output logic [3:0]       masked_status,
  output logic             irq
);
  localparam int HALF = DEPTH / 2;

  irq_vec_t raw, mask_q;
  logic rx_full, ovr_set;

  assign rx_full   = (rx_level == LVL_W'(DEPTH));
  assign ovr_set   = rx_frame_done && rx_full;
  assign rx_accept = rx_frame_done && !rx_full;

  sio_irq_level_cmp #(.LVL_W(LVL_W), .THR(HALF), .AT_ABOVE(1'b0), .RST_VAL(1'b1)) u_tx_low (
    .clk(clk), .rst(rst), .level(tx_level), .flag_q(raw[IDX_TX])
  );

  sio_irq_level_cmp #(.LVL_W(LVL_W), .THR(HALF), .AT_ABOVE(1'b1), .RST_VAL(1'b0)) u_rx_high (
    .clk(clk), .rst(rst), .level(rx_level), .flag_q(raw[IDX_RX])
  );

  sio_irq_rx_timeout #(.LVL_W(LVL_W), .TIMEOUT_BITS(TIMEOUT_BITS)) u_timeout (
    .clk(clk), .rst(rst), .rx_level(rx_level), .rx_pop(rx_pop),
    .frame_done(rx_frame_done), .idle(engine_idle), .bit_tick(bit_tick),
    .sw_clr(clr_wr && clr_wdata[IDX_TO]), .flag_q(raw[IDX_TO])
  );

  sio_irq_sticky u_overrun (
    .clk(clk), .rst(rst), .set(ovr_set),
    .clr(clr_wr && clr_wdata[IDX_OVR]), .flag_q(raw[IDX_OVR])
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign raw_status    = raw;
  assign mask_status   = mask_q;
  assign masked_status = raw & mask_q;
  assign irq           = |(raw & mask_q);
endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_frame_done,
  input logic             mask_wr,
  input logic [3:0]       mask_wdata,
  input logic             clr_wr,
  input logic [3:0]       clr_wdata,
  input logic             rx_accept,
  input logic [3:0]       raw_status,
  input logic [3:0]       mask_status,
  input logic [3:0]       masked_status,
  input logic             irq
);
  localparam int HALF = DEPTH / 2;

  a_r2_tx_low: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LVL_W'(HALF)) |=> raw_status[3]);
  a_r2_tx_high: assert property (@(posedge clk) disable iff (rst)
    (tx_level > LVL_W'(HALF)) |=> !raw_status[3]);
  a_r3_rx_high: assert property (@(posedge clk) disable iff (rst)
    (rx_level >= LVL_W'(HALF)) |=> raw_status[2]);
  a_r5_empty_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !raw_status[1]);
  a_r6_ovr_sets: assert property (@(posedge clk) disable iff (rst)
    (rx_frame_done && rx_level == LVL_W'(DEPTH)) |=> raw_status[0]);
  a_r6_full_refused: assert property (@(posedge clk) disable iff (rst)
    (rx_level == LVL_W'(DEPTH)) |-> !rx_accept);
  a_r7_ovr_holds: assert property (@(posedge clk) disable iff (rst)
    (raw_status[0] && !(clr_wr && clr_wdata[0])) |=> raw_status[0]);
  a_r9_mask_load: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_status == $past(mask_wdata)));
  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((masked_status & ~mask_status) == 4'b0 && mask_status != 4'b0));
endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/tb_sio_irq_ctrl.sv
module tb_sio_irq_ctrl;
  localparam int DEPTH = 8;
  localparam int TOB   = 32;
  localparam int LW    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic rx_frame_done = 0, rx_pop = 0, bit_tick = 0, engine_idle = 0;
  logic mask_wr = 0, clr_wr = 0;
  logic [3:0] mask_wdata = '0, clr_wdata = '0;
  logic rx_accept, irq;
  logic [3:0] raw_status, mask_status, masked_status;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sio_irq_ctrl #(.DEPTH(DEPTH), .TIMEOUT_BITS(TOB)) dut (.*);

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic clr(input logic [3:0] v);
    clr_wr = 1; clr_wdata = v; step(); clr_wr = 0; clr_wdata = '0;
  endtask

  task automatic arm_timeout();
    rx_level = 1; engine_idle = 1; bit_tick = 1; step(TOB); bit_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst = 0;
    step();
    // R1 reset state
    check("R1 raw", raw_status, 8'h8);
    check("R1 mask", mask_status, 8'h0);
    check("R1 masked", masked_status, 8'h0);
    check("R1 irq", irq, 8'h0);

    // R2 / R3 full level sweep
    for (int t = 0; t <= DEPTH; t++) begin
      for (int r = 0; r <= DEPTH; r++) begin
        tx_level = LW'(t); rx_level = LW'(r);
        step();
        check("R2 tx low", raw_status[3], (t <= DEPTH / 2) ? 8'h1 : 8'h0);
        check("R3 rx high", raw_status[2], (r >= DEPTH / 2) ? 8'h1 : 8'h0);
      end
    end

    // R4 ticks on empty FIFO never count
    tx_level = LW'(DEPTH); rx_level = 0; engine_idle = 1; bit_tick = 1;
    step(TOB + 8);
    check("R4 empty no timeout", raw_status[1], 8'h0);

    // R4 exact count
    rx_level = 1;
    step(TOB - 1);
    check("R4 one short", raw_status[1], 8'h0);
    step();
    check("R4 expires", raw_status[1], 8'h1);
    bit_tick = 0;

    // R5 software clear
    clr(4'b0010);
    check("R5 sw clear", raw_status[1], 8'h0);

    // R4 busy cycle restarts count
    bit_tick = 1; step(20);
    engine_idle = 0; step();
    engine_idle = 1; step(20);
    check("R4 busy restart", raw_status[1], 8'h0);
    step(12);
    check("R4 after restart", raw_status[1], 8'h1);
    bit_tick = 0;

    // R5 empty clears
    rx_level = 0; step();
    check("R5 empty clear", raw_status[1], 8'h0);

    // R5 frame done clears; R6 accepted when not full
    arm_timeout();
    check("R4 rearm", raw_status[1], 8'h1);
    rx_frame_done = 1; #1;
    check("R6 accept not full", rx_accept, 8'h1);
    step(); rx_frame_done = 0;
    check("R5 frame clear", raw_status[1], 8'h0);
    check("R6 no overrun", raw_status[0], 8'h0);

    // R5 pop of last word clears
    arm_timeout();
    rx_pop = 1; step(); rx_pop = 0;
    check("R5 pop clear", raw_status[1], 8'h0);

    // R6 overrun
    engine_idle = 0; rx_level = LW'(DEPTH);
    rx_frame_done = 1; #1;
    check("R6 refused at full", rx_accept, 8'h0);
    step(); rx_frame_done = 0;
    check("R6 overrun set", raw_status[0], 8'h1);

    // R7 zero clear bit, simultaneous set+clear, real clear
    clr(4'b1110);
    check("R7 zero no effect", raw_status[0], 8'h1);
    rx_frame_done = 1; clr(4'b0001); rx_frame_done = 0;
    check("R7 set wins", raw_status[0], 8'h1);
    clr(4'b0001);
    check("R7 cleared", raw_status[0], 8'h0);

    // R8 level bits ignore clears
    rx_frame_done = 1; step(); rx_frame_done = 0;
    tx_level = LW'(DEPTH / 2); rx_level = LW'(DEPTH / 2); step();
    clr(4'b1100);
    check("R8 level bits kept", raw_status, 8'hD);

    // R9 / R10 mask sweep on raw = 4'b1101
    for (int m = 0; m < 16; m++) begin
      mask_wr = 1; mask_wdata = 4'(m); step(); mask_wr = 0;
      check("R9 mask", mask_status, 8'(m));
      check("R9 masked", masked_status, 8'(m & 4'hD));
      check("R10 irq", irq, ((m & 4'hD) != 0) ? 8'h1 : 8'h0);
    end

    finish_run();
  end
endmodule